// File: doc/BRIEF.md
# RMII Ethernet Frame Transmitter

This block sends complete IEEE 802.3 frames, two bits per clock, on a reduced media-independent transmit interface. Each frame carries a preamble and start delimiter, a fixed header, a payload of a parameterised number of 32-bit words, and a CRC-32 frame check sequence. The header holds a destination MAC, a source MAC and an EtherType, all set by parameter. After every frame a quiet interval of 48 clocks passes before the next preamble may begin.

Payload words arrive on an AXI4-Stream input and are held in an internal buffer. A frame starts only once a whole payload is waiting, so a frame never stalls halfway. A test-mode input replaces the stream with a free-running 32-bit count that rises by one per word sent, which makes each frame easy to identify at a receiver. A second input picks the order in which the four bytes of each payload word go onto the wire. Both inputs are sampled when a frame starts and are held for that frame.

Top module: `eth_rmii_tx`

## Requirements
- R1: While `rst` is high, `tx_en` and `txd` are 0 and `s_tready` is 1. After `rst` falls, the test count restarts at 0.
- R2: A frame is a single unbroken stretch of `tx_en` high lasting (26 + 4*PAYLOAD_WORDS)*4 clocks. It opens with seven 0x55 bytes and then 0xD5. Every byte goes out over four clocks, bits [1:0] first and bits [7:6] last.
- R3: Bytes 8 to 21 of the frame are the header: DST_MAC, then SRC_MAC, then ETHER_TYPE, each sent most-significant byte first.
- R4: In test mode the payload words are consecutive counter values, one higher per word. The count carries on from one frame to the next.
- R5: With `byte_swap`=0 each payload word goes out with bits [31:24] first. With `byte_swap`=1 it goes out with bits [7:0] first.
- R6: The last four bytes are the CRC-32 of the header and payload, using the reflected polynomial 0xEDB88320 and a start value of 0xFFFFFFFF. The result is complemented and sent least-significant byte first.
- R7: Between the end of one frame and the start of the next, `tx_en` stays low for at least 48 clocks. It is exactly 48 when the next frame is already ready when the gap ends.
- R8: When not in test mode, no frame starts until the buffer holds PAYLOAD_WORDS words. Buffered words are sent in the order they were accepted.
- R9: `s_tready` is low while the buffer holds FIFO_DEPTH words. A word offered during that time is not taken.
- R10: Raising `rst` in the middle of a frame drops `tx_en` on the next clock.
- R11: `test_mode` and `byte_swap` are sampled at frame start. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one dibit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 = payload from the internal count, 0 = from the stream |
| byte_swap | input | 1 | 0 = word MSB byte first, 1 = LSB byte first |
| s_tdata | input | 32 | Stream payload word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Buffer can take a word |
| txd | output | 2 | Transmit dibit |
| tx_en | output | 1 | Transmit enable, high for the whole frame |

## Verification
Two events can land on the same clock edge: the end of the inter-frame gap and the decision to start the next frame. If the next payload is already available, the last gap clock moves the machine straight to the preamble. The bench provokes this with back-to-back test-mode frames, and with stream frames whose words are buffered while the gap is running. It judges the result by the measured gap, which must be exactly 48 low clocks, and by a byte-exact comparison of the frame that follows. A second coincidence is a full buffer refusing a word while a frame is in progress. The bench offers an extra word at that moment and checks that it never appears in the next frame's payload.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_HDR,
        ST_DATA,
        ST_FCS,
        ST_WAIT
    } tx_state_e;

    // Per-frame configuration, captured at frame start (R11)
    typedef struct packed {
        logic use_counter;
        logic lsb_first;
    } frame_cfg_t;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam int          PRE_LEN   = 7;
    localparam int          HDR_LEN   = 14;
    localparam int          FCS_LEN   = 4;
    localparam int          GAP_CLKS  = 48;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLYR = 32'hEDB8_8320;

    // One byte of reflected CRC-32, data taken LSB first
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLYR;
            else                c = c >> 1;
        end
        return c;
    endfunction

    // Header byte idx (0..13): destination, source, EtherType, MSB first
    function automatic logic [7:0] hdr_byte(input logic [47:0] dst,
                                            input logic [47:0] src,
                                            input logic [15:0] etype,
                                            input logic [3:0]  idx);
        logic [47:0] t;
        if (idx < 4'd6) begin
            t = dst >> (8 * (5 - int'(idx)));
        end else if (idx < 4'd12) begin
            t = src >> (8 * (11 - int'(idx)));
        end else begin
            t = {32'h0, etype} >> (8 * (13 - int'(idx)));
        end
        return t[7:0];
    endfunction

    // Byte idx (0..3) of a payload word in wire order
    function automatic logic [7:0] word_byte(input logic [31:0] word,
                                             input logic [1:0]  idx,
                                             input logic        lsb_first);
        logic [31:0] t;
        logic [1:0]  sel;
        sel = lsb_first ? idx : (2'd3 - idx);
        t   = word >> {sel, 3'b000};
        return t[7:0];
    endfunction

    function automatic tx_state_e next_tx(input tx_state_e s);
        case (s)
            ST_PRE:  return ST_SFD;
            ST_SFD:  return ST_HDR;
            ST_HDR:  return ST_DATA;
            ST_DATA: return ST_FCS;
            ST_FCS:  return ST_WAIT;
            default: return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/eth_tx_fifo.sv
module eth_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WIDTH-1:0]           in_data,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       pop,
    output logic [WIDTH-1:0]           out_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push;

    assign in_ready = (level != LW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign out_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init)  crc <= CRC_SEED;
        else if (upd)     crc <= crc32_byte(crc, data);
    end
endmodule

// File: rtl/eth_tx_word_src.sv
module eth_tx_word_src #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             use_counter,
    input  logic [WIDTH-1:0] fifo_data,
    output logic             fifo_pop,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] count;

    assign fifo_pop = load && !use_counter;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            word  <= '0;
        end else if (load) begin
            word <= use_counter ? count : fifo_data;
            if (use_counter) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/eth_rmii_tx.sv
module eth_rmii_tx
    import eth_tx_pkg::*;
#(
    parameter int          PAYLOAD_WORDS = 12,
    parameter int          FIFO_DEPTH    = 16,
    parameter logic [47:0] DST_MAC       = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC       = 48'h02_AA_BB_CC_DD_EE,
    parameter logic [15:0] ETHER_TYPE    = 16'h88B5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        test_mode,
    input  logic        byte_swap,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    output logic [1:0]  txd,
    output logic        tx_en
);
    localparam int DATA_BYTES = 4 * PAYLOAD_WORDS;
    localparam int CNT_MAX    = (DATA_BYTES > GAP_CLKS) ? DATA_BYTES : GAP_CLKS;
    localparam int CNT_W      = $clog2(CNT_MAX);
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    tx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_idx;
    logic [1:0]         dib;
    frame_cfg_t         cfg_q;
    logic               cfg_counter;

    logic [LVL_W-1:0]   fifo_level;
    logic [31:0]        fifo_head;
    logic               fifo_pop;
    logic [31:0]        cur_word;
    logic [31:0]        crc;
    logic               start_ok;
    logic               byte_end;
    logic               load_word;
    logic [7:0]         cur_byte;
    logic [7:0]         shifted;
    logic [31:0]        fcs_word;

    assign cfg_counter = cfg_q.use_counter;
    assign start_ok    = test_mode || (fifo_level >= LVL_W'(PAYLOAD_WORDS));
    assign byte_end    = (dib == 2'd3);
    assign tx_en       = (state != ST_IDLE) && (state != ST_WAIT);

    // Payload buffer (R8, R9)
    eth_tx_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .in_data  (s_tdata),
        .in_valid (s_tvalid),
        .in_ready (s_tready),
        .pop      (fifo_pop),
        .out_data (fifo_head),
        .level    (fifo_level)
    );

    // Word for the next four payload bytes: fetched at the end of the
    // last header byte and at each word boundary inside the payload
    assign load_word = byte_end &&
        (((state == ST_HDR)  && (cnt == CNT_W'(HDR_LEN - 1))) ||
         ((state == ST_DATA) && (cnt[1:0] == 2'd3) &&
          (cnt != CNT_W'(DATA_BYTES - 1))));

    eth_tx_word_src #(.WIDTH(32)) u_src (
        .clk         (clk),
        .rst         (rst),
        .load        (load_word),
        .use_counter (cfg_counter),
        .fifo_data   (fifo_head),
        .fifo_pop    (fifo_pop),
        .word        (cur_word)
    );

    // CRC over header and payload bytes, each folded in on its last dibit
    eth_tx_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (state == ST_PRE),
        .upd  (byte_end && ((state == ST_HDR) || (state == ST_DATA))),
        .data (cur_byte),
        .crc  (crc)
    );

    assign fcs_word = ~crc >> {cnt[1:0], 3'b000};

    always_comb begin
        case (state)
            ST_PRE:  cur_byte = PRE_BYTE;
            ST_SFD:  cur_byte = SFD_BYTE;
            ST_HDR:  cur_byte = hdr_byte(DST_MAC, SRC_MAC, ETHER_TYPE, cnt[3:0]);
            ST_DATA: cur_byte = word_byte(cur_word, cnt[1:0], cfg_q.lsb_first);
            ST_FCS:  cur_byte = fcs_word[7:0];
            default: cur_byte = 8'h00;
        endcase
    end

    always_comb begin
        case (state)
            ST_PRE:  last_idx = CNT_W'(PRE_LEN - 1);
            ST_SFD:  last_idx = '0;
            ST_HDR:  last_idx = CNT_W'(HDR_LEN - 1);
            ST_DATA: last_idx = CNT_W'(DATA_BYTES - 1);
            ST_FCS:  last_idx = CNT_W'(FCS_LEN - 1);
            default: last_idx = CNT_W'(GAP_CLKS - 1);
        endcase
    end

    assign shifted = cur_byte >> {dib, 1'b0};
    assign txd     = tx_en ? shifted[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dib   <= '0;
            cfg_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                        dib   <= '0;
                        cfg_q <= '{use_counter: test_mode, lsb_first: byte_swap};
                    end
                end
                ST_WAIT: begin
                    if (cnt == last_idx) begin
                        cnt <= '0;
                        dib <= '0;
                        if (start_ok) begin
                            state <= ST_PRE;
                            cfg_q <= '{use_counter: test_mode, lsb_first: byte_swap};
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    dib <= dib + 1'b1;
                    if (byte_end) begin
                        if (cnt == last_idx) begin
                            cnt   <= '0;
                            state <= next_tx(state);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/eth_rmii_tx_chk.sv
module eth_rmii_tx_chk #(
    parameter int PAYLOAD_WORDS = 12,
    parameter int FIFO_DEPTH    = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           tx_en,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    input logic                           cfg_counter
);
    localparam int FRAME_CLKS = (26 + 4 * PAYLOAD_WORDS) * 4;
    localparam int GAP_MIN    = 48;

    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;
    logic        seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            hi_cnt <= tx_en ? hi_cnt + 1'b1 : '0;
            if (tx_en)               lo_cnt <= '0;
            else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
            if (tx_en) seen_frame <= 1'b1;
        end
    end

    // R2: every completed frame has the full length
    a_r2_frame_len: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> (hi_cnt == 16'(FRAME_CLKS)));

    // R7: quiet interval before every frame after the first
    a_r7_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && seen_frame) |-> (lo_cnt >= 16'(GAP_MIN)));

    // R8: a stream frame begins only with a whole payload buffered
    a_r8_start_full: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && !cfg_counter) |-> ($past(fifo_level) >= PAYLOAD_WORDS));

    // R9: the buffer never holds more than its depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= FIFO_DEPTH);

    // R10: reset silences the line on the next clock
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !tx_en);
endmodule

bind eth_rmii_tx eth_rmii_tx_chk #(
    .PAYLOAD_WORDS (PAYLOAD_WORDS),
    .FIFO_DEPTH    (FIFO_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .fifo_level  (fifo_level),
    .cfg_counter (cfg_counter)
);

// File: tb/eth_rmii_tx_bench.sv
`timescale 1ns/1ps
module eth_rmii_tx_bench;
    localparam int          W     = 12;
    localparam int          DEPTH = 16;
    localparam int          FB    = 26 + 4 * W;
    localparam logic [47:0] DST   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SRC   = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [15:0] ET    = 16'h88B5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_mode = 1'b0;
    logic        byte_swap = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [1:0]  txd;
    logic        tx_en;

    always #2.5 clk = ~clk;

    eth_rmii_tx #(
        .PAYLOAD_WORDS (W), .FIFO_DEPTH (DEPTH),
        .DST_MAC (DST), .SRC_MAC (SRC), .ETHER_TYPE (ET)
    ) u_eth_rmii_tx (
        .clk (clk), .rst (rst), .test_mode (test_mode), .byte_swap (byte_swap),
        .s_tdata (s_tdata), .s_tvalid (s_tvalid), .s_tready (s_tready),
        .txd (txd), .tx_en (tx_en)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Gap monitor: number of low negedge samples before each rise
    int   cyc = 0;
    int   fall_cyc = 0;
    int   last_gap = -1;
    logic prev_en = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (tx_en && !prev_en) last_gap = cyc - fall_cyc;
        if (!tx_en && prev_en) fall_cyc = cyc;
        prev_en = tx_en;
    end

    logic [7:0]  cap_b [0:255];
    int          cap_dibits;
    logic [7:0]  exp_b [0:255];
    logic [31:0] exp_w [0:W-1];

    task automatic capture();
        int k;
        k = 0;
        do @(negedge clk); while (!tx_en);
        while (tx_en) begin
            if (k < 1024) cap_b[k / 4][2 * (k % 4) +: 2] = txd;
            k++;
            @(negedge clk);
        end
        cap_dibits = k;
    endtask

    // Expected frame built from the requirements; CRC in MSB-first form
    task automatic build_expected(input bit lsb);
        logic [31:0] c;
        logic        fb;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        for (int i = 0; i < 6; i++) begin
            exp_b[8 + i]  = DST[47 - 8 * i -: 8];
            exp_b[14 + i] = SRC[47 - 8 * i -: 8];
        end
        exp_b[20] = ET[15:8];
        exp_b[21] = ET[7:0];
        for (int w = 0; w < W; w++)
            for (int j = 0; j < 4; j++)
                exp_b[22 + 4 * w + j] = lsb ? exp_w[w][8 * j +: 8]
                                            : exp_w[w][31 - 8 * j -: 8];
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < 22 + 4 * W; i++)
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ exp_b[i][b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 8; j++)
                exp_b[22 + 4 * W + k][j] = ~c[31 - (8 * k + j)];
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req,
                             input string what);
        int bad;
        bad = -1;
        for (int i = lo; i <= hi; i++)
            if (bad < 0 && cap_b[i] !== exp_b[i]) bad = i;
        if (bad < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, $sformatf("%s byte %0d", what, bad), cap_b[bad], exp_b[bad]);
    endtask

    task automatic check_frame(input string pay_req);
        chk(cap_dibits == 4 * FB, "R2", "frame length in dibits", cap_dibits, 4 * FB);
        if (cap_dibits == 4 * FB) begin
            cmp_range(0, 7, "R2", "preamble/SFD");
            cmp_range(8, 21, "R3", "header");
            cmp_range(22, 21 + 4 * W, pay_req, "payload");
            cmp_range(22 + 4 * W, FB - 1, "R6", "FCS");
        end
    endtask

    task automatic push(input logic [31:0] w);
        bit ok;
        s_tvalid = 1'b1;
        s_tdata  = w;
        forever begin
            ok = s_tready;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!tx_en);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v2 [0:23];
        bit          quiet;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
        chk(txd == 2'b00, "R1", "txd in reset", txd, 0);
        chk(s_tready == 1'b1, "R1", "s_tready in reset", s_tready, 1);
        rst = 1'b0;

        // Empty buffer: nothing sent (R8)
        quiet = 1'b1;
        repeat (20) begin @(negedge clk); if (tx_en) quiet = 1'b0; end
        chk(quiet, "R8", "idle with empty buffer", !quiet, 0);

        // Stream frame, MSB byte first; one word short holds back (R8)
        for (int i = 0; i < W; i++) exp_w[i] = 32'h1000_0000 + 32'h0102_0304 * i;
        for (int i = 0; i < W - 1; i++) push(exp_w[i]);
        s_tvalid = 1'b0;
        quiet = 1'b1;
        repeat (15) begin @(negedge clk); if (tx_en) quiet = 1'b0; end
        chk(quiet, "R8", "no start with W-1 words", !quiet, 0);
        push(exp_w[W - 1]);
        s_tvalid = 1'b0;
        capture();
        build_expected(1'b0);
        check_frame("R8");

        // Fill to the brim while a frame starts; refused word (R9)
        for (int i = 0; i < 24; i++) v2[i] = 32'hC000_0000 ^ (32'h9E37_79B9 * (i + 1));
        fork
            begin
                for (int i = 0; i < DEPTH; i++) push(v2[i]);
                s_tdata = 32'hDEAD_BEEF;
                repeat (3) begin
                    chk(s_tready == 1'b0, "R9", "s_tready when full", s_tready, 0);
                    @(negedge clk);
                end
                s_tvalid = 1'b0;
            end
            capture();
        join
        for (int i = 0; i < W; i++) exp_w[i] = v2[i];
        build_expected(1'b0);
        check_frame("R8");
        for (int i = DEPTH; i < 24; i++) push(v2[i]);
        s_tvalid = 1'b0;
        capture();
        chk(last_gap == 48, "R7", "gap before buffered frame", last_gap, 48);
        for (int i = 0; i < W; i++) exp_w[i] = v2[W + i];
        build_expected(1'b0);
        check_frame("R9");

        // Test mode: counting payload, back-to-back, mid-frame changes (R4 R5 R11)
        test_mode = 1'b1;
        fork
            capture();
            begin wait_rise(); repeat (50) @(negedge clk); byte_swap = 1'b1; end
        join
        for (int i = 0; i < W; i++) exp_w[i] = i;
        build_expected(1'b0);
        check_frame("R11");
        fork
            capture();
            begin wait_rise(); repeat (50) @(negedge clk); test_mode = 1'b0; end
        join
        chk(last_gap == 48, "R7", "gap between counting frames", last_gap, 48);
        for (int i = 0; i < W; i++) exp_w[i] = W + i;
        build_expected(1'b1);
        check_frame("R4");
        chk(cap_b[22] == 8'(W), "R5", "LSB-first first payload byte", cap_b[22], W);
        quiet = 1'b1;
        repeat (100) begin @(negedge clk); if (tx_en) quiet = 1'b0; end
        chk(quiet, "R11", "stops after test_mode drop", !quiet, 0);

        // Reset during a frame (R10), then count restarts (R1)
        byte_swap = 1'b0;
        test_mode = 1'b1;
        wait_rise();
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(tx_en == 1'b0, "R10", "tx_en after mid-frame reset", tx_en, 0);
        chk(txd == 2'b00, "R10", "txd after mid-frame reset", txd, 0);
        @(negedge clk);
        rst = 1'b0;
        fork
            capture();
            begin wait_rise(); repeat (10) @(negedge clk); test_mode = 1'b0; end
        join
        for (int i = 0; i < W; i++) exp_w[i] = i;
        build_expected(1'b0);
        check_frame("R1");

        repeat (60) @(negedge clk);
        summary();
        $finish;
    end
endmodule